// File: doc/BRIEF.md
# Serial Multi-Space Memory Access Slave

This block is a serial peripheral slave that lets a host reach several internal byte-wide memory spaces through a single four-wire serial port. A transaction lasts as long as chip select is held low. Its first byte is a command, its second is a start address, and every byte after that is data. The command picks the transfer direction and one of four spaces: the configuration/status register file, the auxiliary parameter table, the message buffer and the voice data buffer. Each data byte goes to the next address, so a host can move a whole block after sending one address.

The serial pins are brought into the system clock domain through synchronizers, so the serial clock must be slower than a quarter of the system clock. Each space is reached through a simple synchronous memory port. A write is a one-cycle strobe. A read is a one-cycle enable, and the byte must be returned on the next clock. The block prefetches the byte for each read data slot while the previous byte is still on the wire.

Top module: `spiMemSlave`

## Requirements
- R1: Command bit 7 selects the direction (1 = read, 0 = write). Bits 2..0 select the space: 000 register file, 001 auxiliary table, 010 message buffer, 011 voice buffer. Bits 6..3 have no effect. A transaction never strobes a write and a read enable in the same cycle.
- R2: The second byte is the start address. Data byte k of a transaction accesses start address + k, and a write transaction of n data bytes produces exactly n write strobes.
- R3: The register file and the auxiliary table hold 256 bytes each. For these spaces the address wraps from 0xFF to 0x00, and the upper address output bits are 0.
- R4: For the message and voice buffers the address counter is 11 bits wide and wraps from 2047 to 0.
- R5: A transaction moves at most 2048 data bytes. Write data bytes after the 2048th produce no write strobe.
- R6: The interface uses clock mode 0: bits are sampled on the rising serial clock edge, most significant bit first. MISO is 0 during the command and address bytes. Read data appears from the first byte after the address.
- R7: Raising chip select in the middle of a byte ends the transaction. The partial byte is not written, and the next transaction decodes its first byte as a command.
- R8: Space codes 100 to 111 strobe no memory, and every read data byte returns 0x00.
- R9: Out of reset, MISO is 0 and no write strobe or read enable is active.
- R10: Voice data is written with command 0x03 and read back with command 0x83, starting at address 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | Serial clock from the host, idle low |
| spiMosi | input | 1 | Serial data from the host |
| spiCsN | input | 1 | Active-low chip select |
| spiMiso | output | 1 | Serial data to the host |
| memRe | output | SpaceCount | Read enable, one bit per space |
| memWe | output | SpaceCount | Write strobe, one bit per space |
| memAddr | output | AddrWidth | Byte address shared by all spaces |
| memWdata | output | DataWidth | Write data shared by all spaces |
| memRdata | input | SpaceCount*DataWidth | Read data returned one clock after the enable, space s in byte lane s |

## Verification
The bench targets these corner cases:
- A 2049-byte write that starts at 0x10 in the message buffer. It crosses address 2047 and then reaches the burst limit. A counter without the wrap would put byte 2032 somewhere other than address 0. A missing cap would overwrite address 0x10 with the 2049th byte.
- Writes and reads that cross 0xFF in the register file. A design that does not mask the address would leak into address 0x100.
- A transaction cut off five bits into a data byte. A design that flushes the partial byte writes a spurious value. A design that does not reset its phase tracking misreads the next command.
- Commands with the function bits set and commands with unused space codes. A design that decodes the wrong bits strobes a memory that it should leave untouched.

// File: rtl/spiMemPkg.sv
`timescale 1ns/1ps
package spiMemPkg;

  typedef enum logic [1:0] {
    PhCmd,
    PhAddr,
    PhData
  } phaseT;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic latchCmd;
    logic latchAddr;
    logic writeStb;
    logic incAddr;
    logic fetch;
    logic fetchNull;
  } ctlT;

  // status from datapath to control
  typedef struct packed {
    logic csIdle;
    logic byteDone;
    logic isRead;
  } statT;

endpackage

// File: rtl/spiMemDatapath.sv
`timescale 1ns/1ps
module spiMemDatapath
  import spiMemPkg::*;
#(
  parameter int DataWidth      = 8,
  parameter int AddrWidth      = 11,
  parameter int SpaceCount     = 4,
  parameter int SmallSpaces    = 2,
  parameter int SmallAddrWidth = 8,
  parameter int CodeWidth      = 3,
  parameter int SyncStages     = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             sclkIn,
  input  logic                             mosiIn,
  input  logic                             csNIn,
  input  ctlT                              ctl,
  output statT                             stat,
  output logic                             miso,
  output logic [SpaceCount-1:0]            memRe,
  output logic [SpaceCount-1:0]            memWe,
  output logic [AddrWidth-1:0]             memAddr,
  output logic [DataWidth-1:0]             memWdata,
  input  logic [SpaceCount*DataWidth-1:0]  memRdata
);

  localparam int BitW = $clog2(DataWidth);
  localparam logic [BitW-1:0] LastBit = BitW'(DataWidth - 1);

  logic [SyncStages:0]   sclkPipe;
  logic [SyncStages-1:0] mosiPipe;
  logic [SyncStages-1:0] csPipe;
  logic sclkRise, sclkFall, csIdle, mosiBit;

  logic [BitW-1:0]      bitCnt;
  logic [DataWidth-1:0] rxShift;
  logic [DataWidth-1:0] txShift;
  logic                 loadPending;
  logic                 loadNull;
  logic                 isReadReg;
  logic [CodeWidth-1:0] spaceReg;
  logic [AddrWidth-1:0] addr;
  logic [DataWidth-1:0] rdSel;
  logic                 spaceValid;
  logic                 spaceSmall;

  // input synchronizers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      mosiPipe <= '0;
      csPipe   <= '1;
    end else begin
      sclkPipe <= {sclkPipe[SyncStages-1:0], sclkIn};
      mosiPipe <= {mosiPipe[SyncStages-2:0], mosiIn};
      csPipe   <= {csPipe[SyncStages-2:0], csNIn};
    end
  end

  assign sclkRise = sclkPipe[SyncStages-1] & ~sclkPipe[SyncStages];
  assign sclkFall = ~sclkPipe[SyncStages-1] & sclkPipe[SyncStages];
  assign csIdle   = csPipe[SyncStages-1];
  assign mosiBit  = mosiPipe[SyncStages-1];

  // shift registers and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt      <= '0;
      rxShift     <= '0;
      txShift     <= '0;
      loadPending <= 1'b0;
      loadNull    <= 1'b0;
    end else if (csIdle) begin
      bitCnt      <= '0;
      txShift     <= '0;
      loadPending <= 1'b0;
    end else begin
      if (sclkRise) begin
        rxShift <= {rxShift[DataWidth-2:0], mosiBit};
        bitCnt  <= (bitCnt == LastBit) ? '0 : bitCnt + 1'b1;
      end
      loadPending <= ctl.fetch;
      loadNull    <= ctl.fetchNull | ~spaceValid;
      if (loadPending) begin
        txShift <= loadNull ? '0 : rdSel;
      end else if (sclkFall && bitCnt != '0) begin
        txShift <= {txShift[DataWidth-2:0], 1'b0};
      end
    end
  end

  // command fields and address counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isReadReg <= 1'b0;
      spaceReg  <= '0;
      addr      <= '0;
    end else begin
      if (ctl.latchCmd) begin
        isReadReg <= rxShift[DataWidth-1];
        spaceReg  <= rxShift[CodeWidth-1:0];
      end
      if (ctl.latchAddr) begin
        addr <= AddrWidth'(rxShift);
      end else if (ctl.incAddr) begin
        addr <= addr + 1'b1;
      end
    end
  end

  assign spaceValid = int'(spaceReg) < SpaceCount;
  assign spaceSmall = int'(spaceReg) < SmallSpaces;

  always_comb begin
    rdSel = '0;
    for (int g = 0; g < SpaceCount; g++) begin
      if (int'(spaceReg) == g) rdSel = memRdata[g*DataWidth +: DataWidth];
    end
  end

  generate
    for (genvar g = 0; g < SpaceCount; g++) begin : gSpace
      assign memWe[g] = ctl.writeStb & (int'(spaceReg) == g);
      assign memRe[g] = ctl.fetch & ~ctl.fetchNull & (int'(spaceReg) == g);
    end
  endgenerate

  assign memAddr  = spaceSmall ? AddrWidth'(addr[SmallAddrWidth-1:0]) : addr;
  assign memWdata = rxShift;
  assign miso     = txShift[DataWidth-1];

  assign stat.csIdle   = csIdle;
  assign stat.byteDone = sclkRise & (bitCnt == LastBit) & ~csIdle;
  assign stat.isRead   = isReadReg;

  AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !((|memWe) && (|memRe))); // R1

  AST_SMALL_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    ((|memWe[SmallSpaces-1:0]) || (|memRe[SmallSpaces-1:0]))
      |-> (memAddr[AddrWidth-1:SmallAddrWidth] == '0)); // R3

endmodule

// File: rtl/spiMemControl.sv
`timescale 1ns/1ps
module spiMemControl
  import spiMemPkg::*;
#(
  parameter int MaxBurst = 2048
) (
  input  logic clk,
  input  logic rstN,
  input  statT stat,
  output ctlT  ctl,
  output logic inHeader
);

  localparam int CntW = $clog2(MaxBurst + 1);
  localparam logic [CntW-1:0] BurstMax = CntW'(MaxBurst);

  phaseT           phase;
  logic [CntW-1:0] dataCnt;
  logic            fetchDue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PhCmd;
      dataCnt  <= '0;
      fetchDue <= 1'b0;
      ctl      <= '0;
    end else begin
      ctl <= '0;
      if (stat.csIdle) begin
        phase    <= PhCmd;
        dataCnt  <= '0;
        fetchDue <= 1'b0;
      end else begin
        if (fetchDue) begin
          ctl.fetch     <= 1'b1;
          ctl.fetchNull <= (dataCnt >= BurstMax);
          fetchDue      <= 1'b0;
        end
        if (stat.byteDone) begin
          unique case (phase)
            PhCmd: begin
              ctl.latchCmd <= 1'b1;
              phase        <= PhAddr;
            end
            PhAddr: begin
              ctl.latchAddr <= 1'b1;
              phase         <= PhData;
              fetchDue      <= stat.isRead;
            end
            default: begin
              if (stat.isRead) begin
                ctl.incAddr <= 1'b1;
                fetchDue    <= 1'b1;
              end else if (dataCnt < BurstMax) begin
                ctl.writeStb <= 1'b1;
                ctl.incAddr  <= 1'b1;
              end
              if (dataCnt != BurstMax) dataCnt <= dataCnt + 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign inHeader = (phase != PhData);

endmodule

// File: rtl/spiMemSlave.sv
`timescale 1ns/1ps
module spiMemSlave
  import spiMemPkg::*;
#(
  parameter int DataWidth      = 8,
  parameter int AddrWidth      = 11,
  parameter int SpaceCount     = 4,
  parameter int SmallSpaces    = 2,
  parameter int SmallAddrWidth = 8,
  parameter int CodeWidth      = 3,
  parameter int SyncStages     = 2,
  parameter int MaxBurst       = 2048
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            spiSclk,
  input  logic                            spiMosi,
  input  logic                            spiCsN,
  output logic                            spiMiso,
  output logic [SpaceCount-1:0]           memRe,
  output logic [SpaceCount-1:0]           memWe,
  output logic [AddrWidth-1:0]            memAddr,
  output logic [DataWidth-1:0]            memWdata,
  input  logic [SpaceCount*DataWidth-1:0] memRdata
);

  ctlT  ctl;
  statT stat;
  logic inHeader;

  spiMemControl #(
    .MaxBurst(MaxBurst)
  ) uControl (
    .clk      (clk),
    .rstN     (rstN),
    .stat     (stat),
    .ctl      (ctl),
    .inHeader (inHeader)
  );

  spiMemDatapath #(
    .DataWidth      (DataWidth),
    .AddrWidth      (AddrWidth),
    .SpaceCount     (SpaceCount),
    .SmallSpaces    (SmallSpaces),
    .SmallAddrWidth (SmallAddrWidth),
    .CodeWidth      (CodeWidth),
    .SyncStages     (SyncStages)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .sclkIn   (spiSclk),
    .mosiIn   (spiMosi),
    .csNIn    (spiCsN),
    .ctl      (ctl),
    .stat     (stat),
    .miso     (spiMiso),
    .memRe    (memRe),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memRdata (memRdata)
  );

  AST_MISO_HEADER: assert property (@(posedge clk) disable iff (!rstN)
    inHeader |-> (spiMiso == 1'b0)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (stat.csIdle && $past(stat.csIdle)) |-> ((memWe == '0) && (memRe == '0))); // R7

endmodule

// File: tb/spiMemSlave_test.sv
`timescale 1ns/1ps
module spiMemSlave_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic csN = 1'b1;
  logic miso;
  logic [3:0] memRe, memWe;
  logic [10:0] memAddr;
  logic [7:0] memWdata;
  logic [31:0] memRdata = '0;

  int checks = 0;
  int failures = 0;
  int wrCount = 0;
  int reCount = 0;
  logic [7:0] memModel [int];

  always #2.5 clk = ~clk;

  spiMemSlave uut (
    .clk(clk), .rstN(rstN), .spiSclk(sclk), .spiMosi(mosi), .spiCsN(csN),
    .spiMiso(miso), .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // synchronous memory model, one byte lane per space
  always @(posedge clk) begin
    for (int s = 0; s < 4; s++) begin
      if (memWe[s]) begin
        memModel[s*4096 + int'(memAddr)] = memWdata;
        wrCount++;
      end
      if (memRe[s]) begin
        memRdata[s*8 +: 8] <= memModel.exists(s*4096 + int'(memAddr)) ?
                              memModel[s*4096 + int'(memAddr)] : 8'h00;
        reCount++;
      end
    end
  end

  function automatic logic [7:0] peek(int s, int a);
    return memModel.exists(s*4096 + a) ? memModel[s*4096 + a] : 8'h00;
  endfunction

  function automatic logic [7:0] pattern(int i);
    return 8'(i & 255) ^ 8'(i >> 8);
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic spiBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - n; b--) begin
      mosi = tx[b];
      tick(4);
      sclk = 1'b1;
      rx[b] = miso;
      tick(4);
      sclk = 1'b0;
    end
  endtask

  task automatic csLow();
    csN = 1'b0;
    tick(4);
  endtask

  task automatic csHigh();
    tick(4);
    csN = 1'b1;
    tick(6);
  endtask

  // {command, address, data0, data1, data2}; read entries hold expected bytes
  localparam int NV = 15;
  localparam logic [39:0] VEC [0:NV-1] = '{
    40'h00_10_A1B2C3, // R1 R2 write register file
    40'h80_10_A1B2C3, // R1 R2 R6 read register file
    40'h01_10_112233, // R1 write auxiliary table
    40'h81_10_112233, // R1 read auxiliary table
    40'h80_10_A1B2C3, // R1 spaces kept apart
    40'h03_00_5A6B7C, // R10 voice write
    40'h83_00_5A6B7C, // R10 voice read
    40'h7A_20_445566, // R1 function bits set, message buffer
    40'hF2_20_445566, // R1 function bits set, read back
    40'h00_FE_D1D2D3, // R3 wrap 0xFF to 0x00
    40'h80_FF_D2D300, // R3 read across wrap
    40'h85_10_000000, // R8 unused space read
    40'h06_10_EEEEEE, // R8 unused space write
    40'h82_10_000000, // R8 message buffer untouched
    40'h81_10_112233  // R8 auxiliary table untouched
  };

  initial begin
    logic [7:0] rx0, rx1, rx;
    logic [23:0] got;
    int wrBefore, reBefore;

    tick(5);
    rstN = 1'b1;
    tick(3);
    check(miso == 1'b0 && memWe == '0 && memRe == '0, "R9 reset state",
          {23'd0, miso, memWe, memRe}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] cmd;
      cmd = VEC[v][39:32];
      wrBefore = wrCount;
      reBefore = reCount;
      csLow();
      spiBits(cmd, 8, rx0);
      spiBits(VEC[v][31:24], 8, rx1);
      for (int k = 0; k < 3; k++) begin
        spiBits(cmd[7] ? 8'h00 : VEC[v][23-8*k -: 8], 8, rx);
        got[23-8*k -: 8] = rx;
      end
      csHigh();
      check({rx0, rx1} == 16'h0, $sformatf("R6 header miso vector %0d", v),
            {16'h0, rx0, rx1}, 32'h0);
      if (cmd[7]) begin
        check(got == VEC[v][23:0], $sformatf("R1 R2 read data vector %0d", v),
              {8'h0, got}, {8'h0, VEC[v][23:0]});
      end
      if (cmd[2]) begin
        check(wrCount == wrBefore && reCount == reBefore,
              $sformatf("R8 no strobes vector %0d", v),
              32'(wrCount - wrBefore + reCount - reBefore), 32'd0);
      end else if (!cmd[7]) begin
        check(wrCount == wrBefore + 3, $sformatf("R2 write count vector %0d", v),
              32'(wrCount - wrBefore), 32'd3);
      end
    end

    // R7: abort five bits into a data byte
    wrBefore = wrCount;
    csLow();
    spiBits(8'h00, 8, rx);
    spiBits(8'h40, 8, rx);
    spiBits(8'h99, 8, rx);
    spiBits(8'h77, 5, rx);
    csHigh();
    check(wrCount == wrBefore + 1, "R7 one write before abort",
          32'(wrCount - wrBefore), 32'd1);
    check(peek(0, 'h40) == 8'h99, "R7 full byte written", {24'h0, peek(0, 'h40)}, 32'h99);
    check(!memModel.exists(0*4096 + 'h41), "R7 partial byte dropped",
          {24'h0, peek(0, 'h41)}, 32'h0);
    csLow();
    spiBits(8'h80, 8, rx0);
    spiBits(8'h40, 8, rx1);
    spiBits(8'h00, 8, rx);
    csHigh();
    check(rx == 8'h99, "R7 next command decoded", {24'h0, rx}, 32'h99);

    // R4 R5: 2049-byte write into the message buffer from 0x10
    wrBefore = wrCount;
    csLow();
    spiBits(8'h02, 8, rx);
    spiBits(8'h10, 8, rx);
    for (int i = 0; i < 2049; i++) spiBits(pattern(i), 8, rx);
    csHigh();
    check(peek(2, 'h7FF) == pattern(2031), "R4 last address before wrap",
          {24'h0, peek(2, 'h7FF)}, {24'h0, pattern(2031)});
    check(peek(2, 0) == pattern(2032), "R4 wrap to address 0",
          {24'h0, peek(2, 0)}, {24'h0, pattern(2032)});
    check(peek(2, 'h10) == pattern(0), "R5 byte past limit not written",
          {24'h0, peek(2, 'h10)}, {24'h0, pattern(0)});
    check(wrCount == wrBefore + 2048, "R5 write count capped",
          32'(wrCount - wrBefore), 32'd2048);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule